// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic datapath of a small eight-bit processor core, combined with the eight-bit status register that the datapath reads and updates. On each clock cycle the core presents an operation code, a destination operand, a source operand, a second byte for the pair operation, a six-bit immediate, a bit index, and an optional direct write to the status byte. The result is combinational. It is `DATA_W` bits wide, or `2*DATA_W` bits wide for the pair add. The status register takes the new flag values on the next rising edge.

Status bit positions are fixed and are listed from bit 7 down to bit 0:
- I: interrupt enable
- T: bit-transfer flag
- H: carry or borrow out of bit 3
- S: sign, equal to N xor V
- V: signed overflow
- N: result bit 7
- Z: result is zero
- C: carry or borrow

A flag that an operation does not name keeps its value. Register file, decode and memory access are outside the block.

Top module: `alu8_status`

## Requirements
- R1: Reset clears the status byte to 0x00. When `sr_we` is 1, `sr_wdata` is loaded whole into the status byte (bit 7 I, 6 T, 5 H, 4 S, 3 V, 2 N, 1 Z, 0 C) on that edge. This write takes priority over any operation code in the same cycle.
- R2: Opcode 1 gives rd+rr and opcode 2 gives rd+rr+C. Both update H (carry out of bit 3), V (signed overflow), N, S=N^V, Z and C (carry out of bit 7).
- R3: Opcode 3 gives rd-rr and opcode 4 gives 0-rd. C is set on a borrow out of bit 7 and H on a borrow out of bit 3. V, N, S and Z are updated as in R2.
- R4: Opcode 5 gives rd+1 and opcode 6 gives rd-1. V, N, S and Z are updated, while C and H keep their values.
- R5: Opcodes 8, 9 and 10 give rd AND rr, rd OR rr and rd XOR rr. They clear V, update N, S and Z, and leave C and H unchanged.
- R6: Opcode 11 gives the one's complement of rd. It sets C, clears V and updates N, S and Z.
- R7: Opcode 12 shifts left with a zero fill, and C takes bit 7 while H takes bit 3. Opcode 13 shifts right with a zero fill, and opcode 16 shifts right keeping bit 7. For opcodes 13 and 16, C takes bit 0. For all three, V=N^C and S=N^V.
- R8: Opcode 14 rotates left through C and opcode 15 rotates right through C. The old C fills the vacated bit and the bit shifted out becomes C. Opcode 14 also loads H from bit 3, and both opcodes update V=N^C.
- R9: Opcode 17 exchanges the two nibbles of rd and leaves every status bit unchanged.
- R10: Opcode 18 copies bit `bit_sel` of rd into T. Opcode 19 returns rd with bit `bit_sel` replaced by T, and no flag changes.
- R11: Opcode 20 sets status bit `bit_sel` and opcode 21 clears it. Every other status bit is untouched.
- R12: Opcode 7 returns {rd_hi,rd} + kimm as a 16-bit result, with kimm in the range 0..63. C is the carry out of bit 15, V is set when bit 15 rises from 0 to 1, and N is bit 15. Z is set only when all 16 bits are zero. H is unchanged. All other opcodes return 0 in the upper byte.
- R13: Opcode 0, and any operation that leaves a flag unnamed, keeps the previous value of that flag. In particular, I and T survive every arithmetic operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 5 | Operation code (0..21, see requirements) |
| rd | input | DATA_W | Destination operand, or low byte of the pair |
| rd_hi | input | DATA_W | High byte of the pair for opcode 7 |
| rr | input | DATA_W | Source operand |
| kimm | input | IMM_W | Immediate for the pair add |
| bit_sel | input | BSEL_W | Bit index for opcodes 18 to 21 |
| sr_we | input | 1 | Direct status write enable |
| sr_wdata | input | 8 | Direct status write value |
| result | output | 2*DATA_W | Combinational result |
| status | output | 8 | Registered status byte |

## Verification
The bench targets the boundary cases of the flag logic:
- **Signed overflow.** It drives 0x7F+1 and 0x80+0x80, and a design with a wrong overflow term would report V cleared there.
- **Zero flag of the pair add.** It adds one to 0x00FF. Here the low byte is zero but the pair is not, so a design that tests only the low byte would set Z.
- **Borrow polarity.** It checks subtraction through zero and negation of 0x00 and 0x80, where an inverted carry shows up at once.
- **Rotates and the flags they must not touch.** It rotates with the old carry set, which exposes a zero fill. It also confirms that the increment, decrement and logic operations leave C and H alone.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [4:0] {
      OP_NOP  = 5'd0,
      OP_ADD  = 5'd1,
      OP_ADC  = 5'd2,
      OP_SUB  = 5'd3,
      OP_NEG  = 5'd4,
      OP_INC  = 5'd5,
      OP_DEC  = 5'd6,
      OP_ADIW = 5'd7,
      OP_AND  = 5'd8,
      OP_OR   = 5'd9,
      OP_XOR  = 5'd10,
      OP_COM  = 5'd11,
      OP_LSL  = 5'd12,
      OP_LSR  = 5'd13,
      OP_ROL  = 5'd14,
      OP_ROR  = 5'd15,
      OP_ASR  = 5'd16,
      OP_SWAP = 5'd17,
      OP_BST  = 5'd18,
      OP_BLD  = 5'd19,
      OP_BSET = 5'd20,
      OP_BCLR = 5'd21
   } alu_op_e;

   localparam int OP_W = 5;
   localparam int SR_W = 8;

   // fixed status bit positions
   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_N = 2;
   localparam int FL_V = 3;
   localparam int FL_S = 4;
   localparam int FL_H = 5;
   localparam int FL_T = 6;
   localparam int FL_I = 7;

   function automatic logic op_is_arith(alu_op_e o);
      return (o >= OP_ADD) && (o <= OP_ADIW);
   endfunction

   function automatic logic op_is_bitwise(alu_op_e o);
      return (o >= OP_AND) && (o <= OP_BCLR);
   endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int W     = 8,
   parameter int IMM_W = 6
) (
   input  alu_op_e          op,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     a_hi,
   input  logic [W-1:0]     b,
   input  logic [IMM_W-1:0] imm,
   input  logic [SR_W-1:0]  sr_in,
   output logic [2*W-1:0]   res,
   output logic [SR_W-1:0]  sr_out
);
   localparam int HB = W / 2;

   logic [W-1:0]   x, yy, ym;
   logic           cin, sub, ci;
   logic [W:0]     sum;
   logic [HB:0]    lo;
   logic [2*W:0]   wsum;
   logic           cout, hc, vv;

   always_comb begin
      x   = a;
      yy  = b;
      cin = 1'b0;
      sub = 1'b0;
      unique case (op)
         OP_ADC: cin = sr_in[FL_C];
         OP_SUB: sub = 1'b1;
         OP_NEG: begin x = '0; yy = a; sub = 1'b1; end
         OP_INC: yy = W'(1);
         OP_DEC: begin yy = W'(1); sub = 1'b1; end
         default: ;
      endcase
      ym   = sub ? ~yy : yy;
      ci   = sub | cin;
      sum  = {1'b0, x} + {1'b0, ym} + (W+1)'(ci);
      lo   = {1'b0, x[HB-1:0]} + {1'b0, ym[HB-1:0]} + (HB+1)'(ci);
      cout = sub ? ~sum[W] : sum[W];
      hc   = sub ? ~lo[HB] : lo[HB];
      vv   = (x[W-1] == ym[W-1]) && (sum[W-1] != x[W-1]);
      wsum = {1'b0, a_hi, a} + (2*W+1)'(imm);

      sr_out = sr_in;
      res    = {{W{1'b0}}, sum[W-1:0]};
      if (op == OP_ADIW) begin
         res          = wsum[2*W-1:0];
         sr_out[FL_C] = wsum[2*W];
         sr_out[FL_V] = ~a_hi[W-1] & wsum[2*W-1];
         sr_out[FL_N] = wsum[2*W-1];
         sr_out[FL_Z] = (wsum[2*W-1:0] == '0);
         sr_out[FL_S] = wsum[2*W-1] ^ (~a_hi[W-1] & wsum[2*W-1]);
      end else begin
         sr_out[FL_V] = vv;
         sr_out[FL_N] = sum[W-1];
         sr_out[FL_Z] = (sum[W-1:0] == '0);
         sr_out[FL_S] = sum[W-1] ^ vv;
         if (op != OP_INC && op != OP_DEC) begin
            sr_out[FL_C] = cout;
            sr_out[FL_H] = hc;
         end
      end
   end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter int BSEL_W = 3
) (
   input  alu_op_e           op,
   input  logic [W-1:0]      a,
   input  logic [W-1:0]      b,
   input  logic [BSEL_W-1:0] bsel,
   input  logic [SR_W-1:0]   sr_in,
   output logic [W-1:0]      res,
   output logic [SR_W-1:0]   sr_out
);
   localparam int HB = W / 2;

   logic [2:0] fsel;
   logic       upd_nzs, is_shift, c_new, n_new, v_new;

   assign fsel = bsel[2:0];

   always_comb begin
      res      = a;
      sr_out   = sr_in;
      upd_nzs  = 1'b1;
      is_shift = 1'b0;
      c_new    = sr_in[FL_C];
      unique case (op)
         OP_AND: res = a & b;
         OP_OR:  res = a | b;
         OP_XOR: res = a ^ b;
         OP_COM: begin res = ~a; c_new = 1'b1; end
         OP_LSL: begin
            res = {a[W-2:0], 1'b0}; c_new = a[W-1];
            sr_out[FL_H] = a[HB-1]; is_shift = 1'b1;
         end
         OP_LSR: begin res = {1'b0, a[W-1:1]}; c_new = a[0]; is_shift = 1'b1; end
         OP_ROL: begin
            res = {a[W-2:0], sr_in[FL_C]}; c_new = a[W-1];
            sr_out[FL_H] = a[HB-1]; is_shift = 1'b1;
         end
         OP_ROR: begin res = {sr_in[FL_C], a[W-1:1]}; c_new = a[0]; is_shift = 1'b1; end
         OP_ASR: begin res = {a[W-1], a[W-1:1]}; c_new = a[0]; is_shift = 1'b1; end
         OP_SWAP: begin res = {a[HB-1:0], a[W-1:HB]}; upd_nzs = 1'b0; end
         OP_BST: begin sr_out[FL_T] = a[bsel]; upd_nzs = 1'b0; end
         OP_BLD: begin res[bsel] = sr_in[FL_T]; upd_nzs = 1'b0; end
         OP_BSET: begin sr_out[fsel] = 1'b1; upd_nzs = 1'b0; end
         OP_BCLR: begin sr_out[fsel] = 1'b0; upd_nzs = 1'b0; end
         default: upd_nzs = 1'b0;
      endcase
      n_new = res[W-1];
      v_new = is_shift ? (n_new ^ c_new) : 1'b0;
      if (upd_nzs) begin
         sr_out[FL_C] = c_new;
         sr_out[FL_N] = n_new;
         sr_out[FL_V] = v_new;
         sr_out[FL_Z] = (res == '0);
         sr_out[FL_S] = n_new ^ v_new;
      end
   end
endmodule

// File: rtl/alu8_sreg.sv
module alu8_sreg
   import alu8_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [SR_W-1:0] wdata,
   input  logic [SR_W-1:0] nxt,
   output logic [SR_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
      else         q <= nxt;
   end

   // R1: a direct write lands unaltered
   p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> q == $past(wdata));
endmodule

// File: rtl/alu8_status.sv
module alu8_status
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IMM_W  = 6,
   parameter int BSEL_W = $clog2(DATA_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [OP_W-1:0]     op,
   input  logic [DATA_W-1:0]   rd,
   input  logic [DATA_W-1:0]   rd_hi,
   input  logic [DATA_W-1:0]   rr,
   input  logic [IMM_W-1:0]    kimm,
   input  logic [BSEL_W-1:0]   bit_sel,
   input  logic                sr_we,
   input  logic [SR_W-1:0]     sr_wdata,
   output logic [2*DATA_W-1:0] result,
   output logic [SR_W-1:0]     status
);
   localparam int RES_W = 2 * DATA_W;

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("DATA_W must be even and at least 8");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("IMM_W must lie in 1..DATA_W");
      end
      if (BSEL_W < 3) begin : g_bad_bsel
         $error("BSEL_W must reach every status bit");
      end
   endgenerate

   alu_op_e                opc;
   logic [RES_W-1:0]       ar_res;
   logic [DATA_W-1:0]      bw_res;
   logic [SR_W-1:0]        ar_sr, bw_sr, sr_nxt;

   assign opc = alu_op_e'(op);

   alu8_arith #(.W(DATA_W), .IMM_W(IMM_W)) u_arith (
      .op(opc), .a(rd), .a_hi(rd_hi), .b(rr), .imm(kimm),
      .sr_in(status), .res(ar_res), .sr_out(ar_sr)
   );

   alu8_bitops #(.W(DATA_W), .BSEL_W(BSEL_W)) u_bitops (
      .op(opc), .a(rd), .b(rr), .bsel(bit_sel),
      .sr_in(status), .res(bw_res), .sr_out(bw_sr)
   );

   always_comb begin
      if (op_is_arith(opc)) begin
         result = ar_res;
         sr_nxt = ar_sr;
      end else if (op_is_bitwise(opc)) begin
         result = {{DATA_W{1'b0}}, bw_res};
         sr_nxt = bw_sr;
      end else begin
         result = '0;
         sr_nxt = status;
      end
   end

   alu8_sreg u_sreg (
      .clk(clk), .rst_n(rst_n), .we(sr_we), .wdata(sr_wdata),
      .nxt(sr_nxt), .q(status)
   );

   // R12: upper half only carries data for the pair add
   always_comb begin
      if (rst_n && opc != OP_ADIW)
         a_upper_zero_r12: assert (result[RES_W-1:DATA_W] == '0);
   end

   p_nop_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_we && opc == OP_NOP) |=> $stable(status));

   p_arith_keeps_it_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_we && op_is_arith(opc)) |=> status[FL_I:FL_T] == $past(status[FL_I:FL_T]));

   p_logic_v_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_we && (opc == OP_AND || opc == OP_OR || opc == OP_XOR))
      |=> !status[FL_V] && status[FL_C] == $past(status[FL_C]) && status[FL_H] == $past(status[FL_H]));

   p_com_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_we && opc == OP_COM) |=> status[FL_C] && !status[FL_V]);

   p_incdec_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_we && (opc == OP_INC || opc == OP_DEC))
      |=> status[FL_C] == $past(status[FL_C]) && status[FL_H] == $past(status[FL_H]));

   p_swap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_we && opc == OP_SWAP) |=> $stable(status));
endmodule

// File: tb/alu8_status_bench.sv
module alu8_status_bench;
   localparam int W = 8;
   localparam logic [4:0] K_NOP = 0, K_ADD = 1, K_ADC = 2, K_SUB = 3, K_NEG = 4,
      K_INC = 5, K_DEC = 6, K_ADIW = 7, K_AND = 8, K_OR = 9, K_XOR = 10, K_COM = 11,
      K_LSL = 12, K_LSR = 13, K_ROL = 14, K_ROR = 15, K_ASR = 16, K_SWAP = 17,
      K_BST = 18, K_BLD = 19, K_BSET = 20, K_BCLR = 21;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [4:0]    op = K_NOP;
   logic [W-1:0]  rd = '0, rd_hi = '0, rr = '0;
   logic [5:0]    kimm = '0;
   logic [2:0]    bit_sel = '0;
   logic          sr_we = 1'b0;
   logic [7:0]    sr_wdata = '0;
   logic [15:0]   result;
   logic [7:0]    status;
   int            n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   alu8_status u_alu8_status (
      .clk(clk), .rst_n(rst_n), .op(op), .rd(rd), .rd_hi(rd_hi), .rr(rr),
      .kimm(kimm), .bit_sel(bit_sel), .sr_we(sr_we), .sr_wdata(sr_wdata),
      .result(result), .status(status)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load_sr(input logic [7:0] v);
      @(negedge clk); sr_we = 1'b1; sr_wdata = v;
      @(negedge clk); sr_we = 1'b0;
   endtask

   task automatic run(input string tag, input logic [4:0] o, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] hi, input logic [5:0] k,
                      input logic [2:0] bs, input logic [15:0] exp_res,
                      input logic [7:0] exp_sr);
      @(negedge clk);
      op = o; rd = a; rr = b; rd_hi = hi; kimm = k; bit_sel = bs;
      #2 chk({tag, " result"}, result, exp_res);
      @(negedge clk);
      chk({tag, " status"}, {8'h00, status}, {8'h00, exp_sr});
      op = K_NOP;
   endtask

   task automatic t_reset_write;
      chk("R1 reset status", {8'h00, status}, 16'h0000);
      chk("R1 nop result", result, 16'h0000);
      load_sr(8'hA5);
      chk("R1 write", {8'h00, status}, 16'h00A5);
      @(negedge clk);
      chk("R13 nop hold", {8'h00, status}, 16'h00A5);
      // R1: write wins over an operation in the same cycle
      @(negedge clk); sr_we = 1'b1; sr_wdata = 8'h3C; op = K_ADD; rd = 8'h80; rr = 8'h80;
      @(negedge clk); sr_we = 1'b0; op = K_NOP;
      chk("R1 write priority", {8'h00, status}, 16'h003C);
   endtask

   task automatic t_add;
      load_sr(8'hC0);
      run("R2/R13 add keeps I,T", K_ADD, 8'h0F, 8'h01, 0, 0, 0, 16'h0010, 8'hE0);
      load_sr(8'h00);
      run("R2 add overflow", K_ADD, 8'h7F, 8'h01, 0, 0, 0, 16'h0080, 8'h2C);
      load_sr(8'h00);
      run("R2 add carry zero", K_ADD, 8'h80, 8'h80, 0, 0, 0, 16'h0000, 8'h1B);
      load_sr(8'h01);
      run("R2 adc", K_ADC, 8'h10, 8'h20, 0, 0, 0, 16'h0031, 8'h00);
   endtask

   task automatic t_sub;
      load_sr(8'h00);
      run("R3 sub half", K_SUB, 8'h10, 8'h01, 0, 0, 0, 16'h000F, 8'h20);
      load_sr(8'h00);
      run("R3 sub borrow", K_SUB, 8'h00, 8'h01, 0, 0, 0, 16'h00FF, 8'h35);
      load_sr(8'h00);
      run("R3 sub overflow", K_SUB, 8'h80, 8'h01, 0, 0, 0, 16'h007F, 8'h38);
      load_sr(8'h00);
      run("R3 neg 80", K_NEG, 8'h80, 0, 0, 0, 0, 16'h0080, 8'h0D);
      load_sr(8'h00);
      run("R3 neg 00", K_NEG, 8'h00, 0, 0, 0, 0, 16'h0000, 8'h02);
   endtask

   task automatic t_incdec;
      load_sr(8'h21);
      run("R4 inc keeps C,H", K_INC, 8'h7F, 0, 0, 0, 0, 16'h0080, 8'h2D);
      load_sr(8'h00);
      run("R4 dec", K_DEC, 8'h80, 0, 0, 0, 0, 16'h007F, 8'h18);
      load_sr(8'h00);
      run("R4 inc wrap", K_INC, 8'hFF, 0, 0, 0, 0, 16'h0000, 8'h02);
   endtask

   task automatic t_logic;
      load_sr(8'h29);
      run("R5 and", K_AND, 8'hF0, 8'h8F, 0, 0, 0, 16'h0080, 8'h35);
      load_sr(8'h29);
      run("R5 xor", K_XOR, 8'h5A, 8'h5A, 0, 0, 0, 16'h0000, 8'h23);
      load_sr(8'h00);
      run("R5 or", K_OR, 8'h01, 8'h02, 0, 0, 0, 16'h0003, 8'h00);
      load_sr(8'h00);
      run("R6 com", K_COM, 8'h55, 0, 0, 0, 0, 16'h00AA, 8'h15);
   endtask

   task automatic t_shift;
      load_sr(8'h00);
      run("R7 lsl", K_LSL, 8'h88, 0, 0, 0, 0, 16'h0010, 8'h39);
      load_sr(8'h00);
      run("R7 lsr", K_LSR, 8'h01, 0, 0, 0, 0, 16'h0000, 8'h1B);
      load_sr(8'h00);
      run("R7 asr", K_ASR, 8'h81, 0, 0, 0, 0, 16'h00C0, 8'h15);
      load_sr(8'h01);
      run("R8 rol", K_ROL, 8'h80, 0, 0, 0, 0, 16'h0001, 8'h19);
      load_sr(8'h01);
      run("R8 ror", K_ROR, 8'h02, 0, 0, 0, 0, 16'h0081, 8'h0C);
   endtask

   task automatic t_bits;
      load_sr(8'h81);
      run("R9 swap", K_SWAP, 8'h3C, 0, 0, 0, 0, 16'h00C3, 8'h81);
      load_sr(8'h00);
      run("R10 bst", K_BST, 8'h08, 0, 0, 0, 3'd3, 16'h0008, 8'h40);
      run("R10 bld set", K_BLD, 8'h00, 0, 0, 0, 3'd7, 16'h0080, 8'h40);
      load_sr(8'h00);
      run("R10 bld clear", K_BLD, 8'hFF, 0, 0, 0, 3'd0, 16'h00FE, 8'h00);
      load_sr(8'h00);
      run("R11 bset", K_BSET, 0, 0, 0, 0, 3'd7, 16'h0000, 8'h80);
      load_sr(8'hFF);
      run("R11 bclr", K_BCLR, 0, 0, 0, 0, 3'd0, 16'h0000, 8'hFE);
   endtask

   task automatic t_pair;
      load_sr(8'h00);
      run("R12 pair add", K_ADIW, 8'hFF, 0, 8'h12, 6'd1, 0, 16'h1300, 8'h00);
      load_sr(8'h00);
      run("R12 pair wrap", K_ADIW, 8'hC1, 0, 8'hFF, 6'd63, 0, 16'h0000, 8'h03);
      load_sr(8'h00);
      run("R12 pair overflow", K_ADIW, 8'hFF, 0, 8'h7F, 6'd1, 0, 16'h8000, 8'h0C);
      load_sr(8'h00);
      run("R12 pair Z wide", K_ADIW, 8'hFF, 0, 8'h00, 6'd1, 0, 16'h0100, 8'h00);
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_write();
      t_add();
      t_sub();
      t_incdec();
      t_logic();
      t_shift();
      t_bits();
      t_pair();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule